// File: doc/BRIEF.md
# Paged frame stream packetizer

This block sits between a speech codec and a serial transport. It takes in compressed speech as bytes, where each fixed-length frame stands for 10 ms of audio, and groups the frames into pages of `PAGE_FRAMES` (default 50) data frames. In header mode every page starts with a header frame. The contents of that header are a placeholder here: an index-tagged byte pattern. With headers switched off, only data frames reach the output. The output is a byte stream with a valid flag, a frame-start strobe, a page-start strobe and a header flag.

The page-level run state comes from an operating-mode input and a pause bit. Any change of the mode value restarts the block on a fresh page, and the header-disable configuration bit is captured at that moment. Mode 0 stops the block at once. A pause request does not act mid-page. The block finishes the page it is on and then halts, refusing input until the pause bit drops or the mode goes to 0. Input flow control is a ready signal that is high only while data frames are being taken.

Top module: `pfp_packetizer`

## Requirements
- R1: After reset, and for as long as `mode_i` is 0, `in_ready_o` and `out_valid_o` stay low.
- R2: With headers enabled (latched `hdr_off_i` = 0), each page is one header of `HDR_BYTES` bytes, followed by `PAGE_FRAMES` data frames of `FRAME_BYTES` bytes. Header byte i equals `HDR_BASE + i` (default 8'hA0 + i) and is flagged by `out_hdr_o` = 1. `in_ready_o` is low while the header is being emitted.
- R3: With headers disabled (latched `hdr_off_i` = 1), no header bytes are emitted, and `out_hdr_o` stays 0.
- R4: `out_sof_o` marks the first byte of every header and every data frame. `out_sop_o` marks the first byte of each header, or, when headers are disabled, the first byte of frame 0 of each page.
- R5: The pause bit is sampled on the last byte of a page. If it is set, all remaining frames of that page pass, and then `in_ready_o` stays low and no bytes are emitted. A pause pulse that ends before the page boundary has no effect.
- R6: When the pause bit clears while paused, output resumes on a fresh page, with a header if headers are latched on.
- R7: Setting `mode_i` to 0 stops the block in the same cycle, from any state including paused, and clears the frame position. The next non-zero mode starts a fresh page.
- R8: `hdr_off_i` is captured only when `mode_i` changes value. Changes made while the mode holds steady have no effect on header insertion.
- R9: At a frame boundary, an input byte presented without `in_sof_i` is discarded and produces no output.
- R10: An accepted data byte appears unchanged on `out_data_o` one clock after the edge that accepted it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mode_i | input | MODE_W | Operating mode, 0 = stopped |
| pause_i | input | 1 | Pause request, honoured at page end |
| hdr_off_i | input | 1 | Header disable, latched on mode change |
| in_valid_i | input | 1 | Input byte valid |
| in_sof_i | input | 1 | Input byte is first of a frame |
| in_data_i | input | DATA_W | Input byte |
| in_ready_o | output | 1 | Input byte accepted this cycle if valid |
| out_valid_o | output | 1 | Output byte valid |
| out_data_o | output | DATA_W | Output byte |
| out_sof_o | output | 1 | First byte of a frame or header |
| out_sop_o | output | 1 | First byte of a page |
| out_hdr_o | output | 1 | Byte belongs to a header |

## Verification
The bench aims at the page boundary. A pause that is set mid-page must let the rest of the page through and must stop exactly after the last frame; a design that halts early would drop queued frames, and one that never checks the pause would emit bytes into an empty scoreboard. It also toggles the header-disable bit during a run: a design that tracks that bit live loses the next header. It drops the mode to 0 both mid-page and while paused, then restarts, so a stale page counter shows up as a missing header or page-start strobe. Finally it offers bytes without a start mark at a frame boundary, which a design with no resynchronisation would pass on as extra output.

// File: rtl/pfp_pkg.sv
package pfp_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_HDR   = 2'd1,
    ST_DATA  = 2'd2,
    ST_PAUSE = 2'd3
  } pfp_state_e;
endpackage

// File: rtl/pfp_wrap_ctr.sv
module pfp_wrap_ctr #(
  parameter int unsigned MAX = 1,
  localparam int unsigned W = (MAX > 0) ? $clog2(MAX + 1) : 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o,
  output logic         last_o
);
  assign last_o = (cnt_o == W'(MAX));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_o <= '0;
    else if (clr_i)   cnt_o <= '0;
    else if (inc_i)   cnt_o <= last_o ? '0 : cnt_o + 1'b1;
  end
endmodule

// File: rtl/pfp_mode_track.sv
module pfp_mode_track #(
  parameter int unsigned MODE_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              hdr_off_i,
  output logic              mode_chg_o,
  output logic              hdr_off_o
);
  logic [MODE_W-1:0] mode_q;

  assign mode_chg_o = (mode_i != mode_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q    <= '0;
      hdr_off_o <= 1'b0;
    end else begin
      mode_q <= mode_i;
      // config only taken on a mode transition
      if (mode_chg_o) hdr_off_o <= hdr_off_i;
    end
  end
endmodule

// File: rtl/pfp_packetizer.sv
module pfp_packetizer
  import pfp_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned MODE_W      = 2,
  parameter int unsigned FRAME_BYTES = 10,
  parameter int unsigned HDR_BYTES   = 6,
  parameter int unsigned PAGE_FRAMES = 50,
  parameter logic [7:0]  HDR_BASE    = 8'hA0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              pause_i,
  input  logic              hdr_off_i,
  input  logic              in_valid_i,
  input  logic              in_sof_i,
  input  logic [DATA_W-1:0] in_data_i,
  output logic              in_ready_o,
  output logic              out_valid_o,
  output logic [DATA_W-1:0] out_data_o,
  output logic              out_sof_o,
  output logic              out_sop_o,
  output logic              out_hdr_o
);
  localparam int unsigned BYTE_MAX = FRAME_BYTES - 1;
  localparam int unsigned PAGE_MAX = PAGE_FRAMES - 1;
  localparam int unsigned HDR_MAX  = HDR_BYTES - 1;
  localparam int unsigned BYTE_W   = (BYTE_MAX > 0) ? $clog2(BYTE_MAX + 1) : 1;
  localparam int unsigned PAGE_W   = (PAGE_MAX > 0) ? $clog2(PAGE_MAX + 1) : 1;
  localparam int unsigned HDR_W    = (HDR_MAX > 0) ? $clog2(HDR_MAX + 1) : 1;

  pfp_state_e st_q, st_d;

  logic              mode_chg, hdr_off_q;
  logic              accept, hdr_emit, frame_done, page_end;
  logic [BYTE_W-1:0] byte_cnt;
  logic [PAGE_W-1:0] frame_cnt;
  logic [HDR_W-1:0]  hdr_cnt;
  logic              byte_last, frame_last, hdr_last;
  logic [DATA_W-1:0] hdr_byte;

  pfp_mode_track #(.MODE_W(MODE_W)) u_mode (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mode_i     (mode_i),
    .hdr_off_i  (hdr_off_i),
    .mode_chg_o (mode_chg),
    .hdr_off_o  (hdr_off_q)
  );

  pfp_wrap_ctr #(.MAX(BYTE_MAX)) u_byte_ctr (
    .clk_i (clk_i), .rst_ni (rst_ni), .clr_i (mode_chg), .inc_i (accept),
    .cnt_o (byte_cnt), .last_o (byte_last)
  );

  pfp_wrap_ctr #(.MAX(PAGE_MAX)) u_page_ctr (
    .clk_i (clk_i), .rst_ni (rst_ni), .clr_i (mode_chg), .inc_i (frame_done),
    .cnt_o (frame_cnt), .last_o (frame_last)
  );

  pfp_wrap_ctr #(.MAX(HDR_MAX)) u_hdr_ctr (
    .clk_i (clk_i), .rst_ni (rst_ni), .clr_i (mode_chg), .inc_i (hdr_emit),
    .cnt_o (hdr_cnt), .last_o (hdr_last)
  );

  assign in_ready_o = (st_q == ST_DATA) && !mode_chg;
  // at a frame boundary only a marked byte opens a frame
  assign accept     = in_ready_o && in_valid_i && (in_sof_i || (byte_cnt != '0));
  assign hdr_emit   = (st_q == ST_HDR) && !mode_chg;
  assign frame_done = accept && byte_last;
  assign page_end   = frame_done && frame_last;
  assign hdr_byte   = DATA_W'(HDR_BASE) + DATA_W'(hdr_cnt);

  always_comb begin
    st_d = st_q;
    if (mode_chg) begin
      if (mode_i == '0)   st_d = ST_IDLE;
      else if (hdr_off_i) st_d = ST_DATA;
      else                st_d = ST_HDR;
    end else begin
      unique case (st_q)
        ST_HDR:   if (hdr_last) st_d = ST_DATA;
        ST_DATA:  if (page_end) st_d = pause_i ? ST_PAUSE : (hdr_off_q ? ST_DATA : ST_HDR);
        ST_PAUSE: if (!pause_i) st_d = hdr_off_q ? ST_DATA : ST_HDR;
        default:  st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      out_data_o  <= '0;
      out_sof_o   <= 1'b0;
      out_sop_o   <= 1'b0;
      out_hdr_o   <= 1'b0;
    end else begin
      out_valid_o <= accept || hdr_emit;
      out_data_o  <= hdr_emit ? hdr_byte : in_data_i;
      out_sof_o   <= (hdr_emit && hdr_cnt == '0) || (accept && byte_cnt == '0);
      out_sop_o   <= (hdr_emit && hdr_cnt == '0) ||
                     (accept && byte_cnt == '0 && frame_cnt == '0 && hdr_off_q);
      out_hdr_o   <= hdr_emit;
    end
  end
endmodule

// File: rtl/pfp_packetizer_chk.sv
module pfp_packetizer_chk
  import pfp_pkg::*;
#(
  parameter int unsigned MODE_W = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [MODE_W-1:0] mode_i,
  input logic              in_ready_o,
  input logic              out_valid_o,
  input logic              out_sof_o,
  input logic              out_sop_o,
  input logic              out_hdr_o,
  input pfp_state_e        st_i,
  input logic              page_end_i
);
  // R4
  sop_has_sof_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_sop_o |-> out_sof_o);

  // R2
  hdr_is_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_hdr_o |-> out_valid_o);

  // R7
  mode_off_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == '0) |-> !in_ready_o);

  // R7
  mode_off_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == '0) |=> !out_valid_o);

  // R5
  pause_on_boundary_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i == ST_PAUSE && $past(st_i) != ST_PAUSE) |-> $past(page_end_i));
endmodule

bind pfp_packetizer pfp_packetizer_chk #(.MODE_W(MODE_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .mode_i      (mode_i),
  .in_ready_o  (in_ready_o),
  .out_valid_o (out_valid_o),
  .out_sof_o   (out_sof_o),
  .out_sop_o   (out_sop_o),
  .out_hdr_o   (out_hdr_o),
  .st_i        (st_q),
  .page_end_i  (page_end)
);

// File: tb/pfp_packetizer_tb.sv
module pfp_packetizer_tb;
  localparam int CLK_PERIOD  = 10;
  localparam int FRAME_BYTES = 10;
  localparam int HDR_BYTES   = 6;
  localparam int PAGE_FRAMES = 50;
  localparam logic [7:0] HDR_BASE = 8'hA0;

  typedef struct packed {
    logic [7:0] d;
    logic       sof;
    logic       sop;
    logic       hdr;
  } item_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode = '0;
  logic       pause = 1'b0;
  logic       hdr_off = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_sof = 1'b0;
  logic [7:0] in_data = '0;
  logic       in_ready, out_valid, out_sof, out_sop, out_hdr;
  logic [7:0] out_data;

  item_t exp_q[$];
  int n_cmp = 0;
  int n_bad = 0;
  int pg_frame = 0;
  int fid = 0;
  bit hdr_mode = 1'b1;

  always #(CLK_PERIOD/2) clk = ~clk;

  pfp_packetizer #(
    .FRAME_BYTES (FRAME_BYTES),
    .HDR_BYTES   (HDR_BYTES),
    .PAGE_FRAMES (PAGE_FRAMES),
    .HDR_BASE    (HDR_BASE)
  ) u_dut (
    .clk_i (clk), .rst_ni (rst_n), .mode_i (mode), .pause_i (pause),
    .hdr_off_i (hdr_off), .in_valid_i (in_valid), .in_sof_i (in_sof),
    .in_data_i (in_data), .in_ready_o (in_ready), .out_valid_o (out_valid),
    .out_data_o (out_data), .out_sof_o (out_sof), .out_sop_o (out_sop),
    .out_hdr_o (out_hdr)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      item_t got, exp;
      got = '{d: out_data, sof: out_sof, sop: out_sop, hdr: out_hdr};
      n_cmp++;
      if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL R5 R7 R9: unexpected output actual %0h expected none", got);
      end else begin
        exp = exp_q.pop_front();
        if (got !== exp) begin
          n_bad++;
          $display("FAIL R2 R3 R4 R10: actual %0h expected %0h", got, exp);
        end
      end
    end
  end

  function automatic logic [7:0] fval(input int k, input int j);
    return 8'(k * 7 + j * 29 + 3);
  endfunction

  task automatic push_hdr();
    for (int i = 0; i < HDR_BYTES; i++)
      exp_q.push_back('{d: HDR_BASE + 8'(i), sof: (i == 0), sop: (i == 0), hdr: 1'b1});
  endtask

  task automatic send_frame();
    if (pg_frame == 0 && hdr_mode) push_hdr();
    for (int j = 0; j < FRAME_BYTES; j++)
      exp_q.push_back('{d: fval(fid, j), sof: (j == 0),
                        sop: (j == 0 && pg_frame == 0 && !hdr_mode), hdr: 1'b0});
    for (int j = 0; j < FRAME_BYTES; j++) begin
      in_valid = 1'b1;
      in_sof   = (j == 0);
      in_data  = fval(fid, j);
      while (!in_ready) @(negedge clk);
      @(negedge clk);
    end
    in_valid = 1'b0;
    in_sof   = 1'b0;
    fid++;
    pg_frame = (pg_frame == PAGE_FRAMES - 1) ? 0 : pg_frame + 1;
  endtask

  task automatic send_n(input int n);
    for (int i = 0; i < n; i++) send_frame();
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(4);
    // R1
    chk(!in_ready, "R1 ready after reset", in_ready, 0);
    chk(!out_valid, "R1 valid after reset", out_valid, 0);

    // R2 R4 R10: header mode run into page 2
    hdr_off = 1'b0;
    mode = 2'd1;
    idle(1);
    send_n(PAGE_FRAMES + 3);

    // R9: unmarked bytes at a frame boundary are dropped
    in_valid = 1'b1; in_sof = 1'b0; in_data = 8'h5A;
    idle(1);
    chk(in_ready, "R9 ready at boundary", in_ready, 1);
    idle(2);
    in_valid = 1'b0;
    idle(3);
    chk(exp_q.size() == 0, "R9 no output from unmarked bytes", exp_q.size(), 0);

    // R8: header disable written while running is ignored
    hdr_off = 1'b1;
    // R5: pause pulse before the boundary has no effect
    pause = 1'b1; idle(2); pause = 1'b0;
    send_n(PAGE_FRAMES - 3 - 1 + 1); // up to the next page boundary
    send_n(1);                       // first frame of next page, header expected (R8)

    // R5: pause set mid-page, honoured at page end
    pause = 1'b1;
    send_n(PAGE_FRAMES - 1);
    idle(20);
    chk(!in_ready, "R5 stalled after page end", in_ready, 0);
    chk(exp_q.size() == 0, "R5 all page frames emitted", exp_q.size(), 0);

    // R6: clear pause, fresh page with header
    pause = 1'b0;
    send_n(5);

    // R7: stop mid-page
    mode = 2'd0;
    idle(4);
    chk(!in_ready, "R7 stop mid-page", in_ready, 0);
    chk(exp_q.size() == 0, "R7 no pending output", exp_q.size(), 0);

    // R3 R8: restart latches headers off, fresh page
    mode = 2'd1;
    hdr_mode = 1'b0;
    pg_frame = 0;
    idle(1);
    send_n(PAGE_FRAMES + 2);

    // R5 R3: pause with headers off, then stop while paused
    pause = 1'b1;
    send_n(PAGE_FRAMES - 2);
    idle(10);
    chk(!in_ready, "R5 paused with headers off", in_ready, 0);
    mode = 2'd0;
    idle(2);
    pause = 1'b0;
    idle(6);
    // R7: pause release does not resume once stopped
    chk(!in_ready, "R7 stopped from paused", in_ready, 0);
    chk(!out_valid, "R7 quiet from paused", out_valid, 0);

    // R7 R2: restart with headers on, fresh page
    hdr_off = 1'b0;
    mode = 2'd2;
    hdr_mode = 1'b1;
    pg_frame = 0;
    idle(1);
    send_n(2);
    idle(10);
    chk(exp_q.size() == 0, "R2 scoreboard drained", exp_q.size(), 0);
    finish_run();
  end
endmodule